// File: doc/BRIEF.md
# Round-Robin Multi-Protocol Serial ADC Sampler

This block is a reduced serial master that reads external serial converters on its own, one channel at a time, in a fixed circular order. It drives a divided serial clock and a select strobe, gathers the bits that the selected converter returns on a single shared data input, and stores the finished sample in a per-channel result register. The host reads that register through a combinational read port. A per-channel flag shows which registers have been filled since reset.

A static protocol input picks one of three converter families. In the four-channel family a single multi-input converter is used, and its two channel lines are driven directly. In the two eight-channel families each converter handles one channel, and the channel number leaves the block as a 3-bit code for an external 3-to-8 decoder. The decoder is gated by the active-low strobe. The families differ in sample width and frame length.

The controller is a four-state machine:
- ST_IDLE: strobe high, channel held at 0.
- ST_SHIFT: strobe low, serial clock running.
- ST_COMMIT: one cycle in which the result is written and the channel advances.
- ST_GAP: strobe high for a fixed guard time.

Its transitions:
- ST_IDLE→ST_SHIFT when `enable` is high.
- ST_SHIFT→ST_COMMIT on the falling serial clock edge after the last bit of the frame.
- ST_COMMIT→ST_GAP always.
- ST_GAP→ST_SHIFT at the end of the guard time when `enable` is still high, or ST_GAP→ST_IDLE at the end of the guard time when it is low.

The protocol input is sampled only in ST_IDLE.

Top module: `rr_adc_sampler`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, every `valid` bit is 0 and every result register reads 0.
- R2: While running, channels are visited in ascending order. After the last channel of the active protocol the order wraps to channel 0: the last channel is 3 for `mode`=0 and 7 for `mode`=1 and `mode`=2.
- R3: Data is captured MSB first on each rising `sclk` edge. `mode`=0 uses 14 clocks per frame and keeps the last 12 bits. `mode`=1 uses 16 clocks and keeps the last 15 bits. `mode`=2 uses 16 clocks and keeps all 16 bits. Bits above the kept width read as 0.
- R4: `sclk` has a period of `CLK_DIV` system clocks. It is low whenever `cs_n` is high.
- R5: For `mode`=1 and `mode`=2, `cs_code` carries the channel number 0..7. For `mode`=0, `cs_code[1:0]` carries the channel and `cs_code[2]` is 0. `cs_code` does not change while `cs_n` is low.
- R6: Between two frames `cs_n` stays high for at least `GAP_SCLKS` serial clock periods, which is 2 by default.
- R7: Raising `enable` from idle starts at channel 0. Clearing it lets the current frame finish and be stored, and then no further frame starts. Re-enabling starts again at channel 0.
- R8: A result register changes only after its frame ends (`cs_n` high), in one step. A read through `rd_addr` during a frame returns the previous complete value.
- R9: A `valid` bit is set when its channel is first stored and stays set until reset. Channels beyond the active protocol's count keep `valid` 0 and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request for the circular sampling |
| mode | input | 2 | Protocol select: 0 four-channel 12-bit, 1 eight-channel 15-bit, 2 eight-channel 16-bit |
| sdi | input | 1 | Shared serial data from the converters |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low frame strobe; decoder gate in eight-channel protocols |
| cs_code | output | 3 | Channel code for the decoder, or direct channel lines in the four-channel protocol |
| rd_addr | input | 3 | Result register read address |
| rd_data | output | 16 | Result of the addressed channel, zero-extended |
| valid | output | 8 | Per-channel filled flag |

## Verification
The properties assume that `mode` never takes the reserved value 3 and that `rd_addr` changes only between frames when an atomic read is being judged. The bench keeps to this: it changes `mode` only while the block sits idle under reset, and it moves `rd_addr` only at readout points. The converter model in the bench changes `sdi` only on falling serial clock edges and at strobe assertion, so every captured bit is stable at the rising edge. Each protocol is swept over more than two full rounds, followed by a stop and a restart.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    localparam int MAX_CH   = 8;
    localparam int SAMPLE_W = 16;

    typedef enum logic [1:0] {
        MODE_QUAD12 = 2'd0,
        MODE_OCT15  = 2'd1,
        MODE_OCT16  = 2'd2,
        MODE_RSVD   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_GAP    = 2'd3
    } state_e;

    function automatic logic [4:0] frame_clocks(input mode_e m);
        return (m == MODE_QUAD12) ? 5'd14 : 5'd16;
    endfunction

    function automatic logic [SAMPLE_W-1:0] keep_mask(input mode_e m);
        unique case (m)
            MODE_QUAD12: return 16'h0FFF;
            MODE_OCT15:  return 16'h7FFF;
            default:     return 16'hFFFF;
        endcase
    endfunction

    function automatic logic [2:0] last_channel(input mode_e m);
        return (m == MODE_QUAD12) ? 3'd3 : 3'd7;
    endfunction

endpackage

// File: rtl/rrs_sclk_gen.sv
module rrs_sclk_gen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise,
    output logic fall
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          tick;

    assign tick = run && (cnt_q == CW'(HALF - 1));
    assign rise = tick && !sclk;
    assign fall = tick && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            sclk  <= ~sclk;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rrs_result_bank.sv
module rrs_result_bank #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(NUM_CH)-1:0] wr_ch,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [$clog2(NUM_CH)-1:0] rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    output logic [NUM_CH-1:0]         valid
);
    localparam int AW = $clog2(NUM_CH);

    logic [DATA_W-1:0] res_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q[g] <= '0;
                valid[g] <= 1'b0;
            end else if (wr_en && (wr_ch == AW'(g))) begin
                res_q[g] <= wr_data;
                valid[g] <= 1'b1;
            end
        end
    end

    assign rd_data = res_q[rd_addr];
endmodule

// File: rtl/rr_adc_sampler.sv
module rr_adc_sampler #(
    parameter int CLK_DIV   = 4,
    parameter int GAP_SCLKS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic [1:0]  mode,
    input  logic        sdi,
    output logic        sclk,
    output logic        cs_n,
    output logic [2:0]  cs_code,
    input  logic [2:0]  rd_addr,
    output logic [15:0] rd_data,
    output logic [7:0]  valid
);
    import rrs_pkg::*;

    localparam int GAP_CYC = GAP_SCLKS * CLK_DIV;
    localparam int GW      = $clog2(GAP_CYC + 1);

    state_e              state_q, state_d;
    mode_e               mode_q;
    logic [2:0]          ch_q;
    logic [4:0]          bit_cnt_q;
    logic [GW-1:0]       gap_cnt_q;
    logic [SAMPLE_W-1:0] shreg_q;
    logic                rise, fall;
    logic                wr_en;
    logic [SAMPLE_W-1:0] wr_data;
    logic                gap_done;

    assign gap_done = (gap_cnt_q == GW'(GAP_CYC - 1));

    rrs_sclk_gen #(.CLK_DIV(CLK_DIV)) u_sclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_SHIFT),
        .sclk  (sclk),
        .rise  (rise),
        .fall  (fall)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (enable) state_d = ST_SHIFT;
            ST_SHIFT:  if (fall && bit_cnt_q == frame_clocks(mode_q)) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_GAP;
            ST_GAP:    if (gap_done) state_d = enable ? ST_SHIFT : ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MODE_QUAD12;
            ch_q      <= '0;
            bit_cnt_q <= '0;
            gap_cnt_q <= '0;
            shreg_q   <= '0;
        end else begin
            if (state_q == ST_IDLE) begin
                mode_q <= mode_e'(mode);
                ch_q   <= '0;
            end
            if (state_q == ST_COMMIT)
                ch_q <= (ch_q == last_channel(mode_q)) ? 3'd0 : ch_q + 3'd1;
            if (state_q != ST_SHIFT) bit_cnt_q <= '0;
            else if (rise)           bit_cnt_q <= bit_cnt_q + 5'd1;
            if (rise) shreg_q <= {shreg_q[SAMPLE_W-2:0], sdi};
            gap_cnt_q <= (state_q == ST_GAP) ? gap_cnt_q + 1'b1 : '0;
        end
    end

    // Output decode
    always_comb begin
        cs_n    = (state_q != ST_SHIFT);
        cs_code = (mode_q == MODE_QUAD12) ? {1'b0, ch_q[1:0]} : ch_q;
        wr_en   = (state_q == ST_COMMIT);
        wr_data = shreg_q & keep_mask(mode_q);
    end

    rrs_result_bank #(.NUM_CH(MAX_CH), .DATA_W(SAMPLE_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ch   (ch_q),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .valid   (valid)
    );
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker (
    input logic           clk,
    input logic           rst_n,
    input logic           sclk,
    input logic           cs_n,
    input logic [2:0]     cs_code,
    input logic [2:0]     rd_addr,
    input logic [15:0]    rd_data,
    input logic [7:0]     valid,
    input rrs_pkg::mode_e mode_q
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R4

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(cs_code)); // R5

    AST_QUAD_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && mode_q == rrs_pkg::MODE_QUAD12) |-> (cs_code[2] == 1'b0)); // R5

    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n); // R6

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(valid) & ~valid) == 8'h00)); // R9

    AST_VALID_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(valid) |-> cs_n); // R8

    AST_READ_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && $stable(rd_addr)) |-> $stable(rd_data)); // R8
endmodule

bind rr_adc_sampler rrs_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk    (sclk),
    .cs_n    (cs_n),
    .cs_code (cs_code),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .valid   (valid),
    .mode_q  (mode_q)
);

// File: tb/tb_rr_adc_sampler.sv
module tb_rr_adc_sampler;
    localparam int DIV  = 4;
    localparam int GAPS = 2;
    localparam int TCLK = 10;

    logic        clk = 1'b0;
    logic        rst_n, enable, sdi;
    logic [1:0]  mode;
    logic [2:0]  rd_addr;
    logic        sclk, cs_n;
    logic [2:0]  cs_code;
    logic [15:0] rd_data;
    logic [7:0]  valid;

    rr_adc_sampler #(.CLK_DIV(DIV), .GAP_SCLKS(GAPS)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .sdi(sdi),
        .sclk(sclk), .cs_n(cs_n), .cs_code(cs_code), .rd_addr(rd_addr),
        .rd_data(rd_data), .valid(valid)
    );

    always #5 clk = ~clk;

    int          n_checks, n_fail, frame_no, rises, bitidx, nclk, nch;
    logic [15:0] word, mask;
    logic [15:0] committed [8];
    logic [2:0]  cur_ch, exp_ch;
    time         t_rise, t_last_sclk;
    bit          done;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // Converter model: frame start/end
    task automatic model_frames();
        forever begin
            @(negedge cs_n);
            #1;
            if (t_rise == 0 || ($time - t_rise) > time'((1 + GAPS * DIV) * TCLK + 5)) begin
                check(cs_code == 3'd0, "R7 restart channel", cs_code, 0);
                exp_ch = 3'd0;
            end else begin
                check(($time - t_rise) >= time'(GAPS * DIV * TCLK), "R6 gap", 32'($time - t_rise), GAPS * DIV * TCLK);
                check(cs_code == exp_ch, "R2 order", cs_code, exp_ch);
            end
            if (mode == 2'd0) check(cs_code[2] == 1'b0, "R5 direct lines", cs_code, {1'b0, exp_ch[1:0]});
            cur_ch = cs_code;
            exp_ch = (int'(exp_ch) == nch - 1) ? 3'd0 : exp_ch + 3'd1;
            word   = 16'hA5C3 ^ 16'(frame_no * 32'h3B1D);
            bitidx = nclk - 1;
            sdi    = word[bitidx];
            rises  = 0;
            frame_no++;
            @(posedge cs_n);
            #1;
            check(rises == nclk, "R3 clocks per frame", rises, nclk);
            check(sclk == 1'b0, "R4 sclk idle", sclk, 0);
            committed[cur_ch] = word & mask;
            t_rise = $time - 1;
        end
    endtask

    task automatic model_shift();
        forever begin
            @(negedge sclk);
            if (!cs_n && bitidx > 0) begin
                bitidx--;
                sdi = word[bitidx];
            end
        end
    endtask

    task automatic model_period();
        forever begin
            @(posedge sclk);
            rises++;
            if (rises > 1)
                check(($time - t_last_sclk) == time'(DIV * TCLK), "R4 period", 32'($time - t_last_sclk), DIV * TCLK);
            t_last_sclk = $time;
        end
    endtask

    task automatic do_reset(input bit check_it);
        @(negedge clk);
        rst_n = 1'b0; enable = 1'b0;
        repeat (4) @(negedge clk);
        if (check_it) begin
            check(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
            check(sclk == 1'b0, "R1 sclk", sclk, 0);
            check(valid == 8'h00, "R1 valid", valid, 0);
            for (int a = 0; a < 8; a++) begin
                rd_addr = 3'(a); #1;
                check(rd_data == 16'h0, "R1 result", rd_data, 0);
            end
        end
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_mode(input int m);
        int base, target;
        do_reset(1'b0);
        mode = 2'(m);
        nclk = (m == 0) ? 14 : 16;
        nch  = (m == 0) ? 4 : 8;
        mask = (m == 0) ? 16'h0FFF : (m == 1) ? 16'h7FFF : 16'hFFFF;
        for (int a = 0; a < 8; a++) committed[a] = 16'h0;
        base   = frame_no;
        target = 2 * nch + 2;
        enable = 1'b1;
        wait (frame_no == base + nch + 2);
        #(DIV * TCLK * 3);
        rd_addr = cur_ch; #1;
        check(rd_data == committed[cur_ch], "R8 read during frame", rd_data, committed[cur_ch]);
        wait (frame_no == base + target);
        @(negedge clk); enable = 1'b0;
        repeat (20 * DIV + 40) @(negedge clk);
        check(frame_no == base + target, "R7 stop after frame", frame_no - base, target);
        check(cs_n == 1'b1, "R7 idle strobe", cs_n, 1);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a); #1;
            check(rd_data == committed[a], "R3 stored sample", rd_data, committed[a]);
            check(valid[a] == (a < nch), "R9 valid", valid[a], (a < nch));
        end
        enable = 1'b1;
        wait (frame_no == base + target + 1);
        @(negedge clk); enable = 1'b0;
        repeat (20 * DIV + 40) @(negedge clk);
        check(frame_no == base + target + 1, "R7 restart single", frame_no - base, target + 1);
    endtask

    initial begin
        n_checks = 0; n_fail = 0; frame_no = 0; rises = 0; bitidx = 0;
        nclk = 14; nch = 4; mask = 16'h0FFF; word = 16'h0; exp_ch = 3'd0; cur_ch = 3'd0;
        t_rise = 0; t_last_sclk = 0; done = 1'b0;
        rst_n = 1'b0; enable = 1'b0; mode = 2'd0; sdi = 1'b0; rd_addr = 3'd0;
        fork
            model_frames();
            model_shift();
            model_period();
            begin
                #(150000 * TCLK);
                n_checks++; n_fail++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        join_none
        do_reset(1'b1);
        for (int m = 0; m < 3; m++) run_mode(m);
        finish_run();
    end
endmodule